// File: doc/BRIEF.md
# Multiplexed-Bus Page-Write Memory Peripheral

This block is a byte-wide memory slave that hangs directly on a microcontroller bus whose low address byte and data share the same eight lines. An address strobe (`ale`) makes the address register transparent while it is high and freezes it when it falls. After that the shared lines carry data. Reads are served on either of two active-low read strobes, one for program fetch and one for data. Writes do not go straight into the array. They are collected in a page buffer and then written into the array together in one timed internal write cycle.

Write control is a three-state machine. `ST_IDLE` waits for the first accepted write; that byte is buffered and the transition *first-write* leads to `ST_LOAD`. In `ST_LOAD` each further write to the same page is buffered and restarts a byte-load timer. When the timer expires, the transition *load-timeout* enters `ST_PROG`. `ST_PROG` holds for a programmable number of cycles. The transition *program-done* then copies every buffered byte into the array and returns to `ST_IDLE`. While `ST_PROG` is active, reads return a status byte with a toggling bit, so the host can poll for the end of the write cycle.

The storage is a register array of 2^`ADDR_W` bytes. The default is kept small for elaboration; a full 32K x 8 build sets `ADDR_W` to 15. A page holds 128 bytes, selected by the address bits above bit 6.

Top module: `mpx_page_mem`

## Requirements
- R1: While `ale` is high the address used for a read follows `{a_hi, ad_i}` directly. After `ale` falls, the address captured on the last clock with `ale` high is held, and later changes on `ad_i`/`a_hi` do not alter which byte is read.
- R2: With the chip selected (`ce_n`=0 and `ce`=1) and `wr_n`=1, pulling either `rd_n` or `psen_n` low drives the addressed byte on `ad_o` with `ad_oe`=1. With no read strobe low, `ad_oe`=0.
- R3: When `ce_n`=1 or `ce`=0, `ad_oe` stays 0 and a `wr_n` pulse stores nothing.
- R4: A write is accepted on the clock where `wr_n` is first seen low while the chip is selected and `ale` is low. Buffered bytes are not visible to reads until `ST_PROG` completes. Then all buffered bytes reach the array together, and bytes of the page that were not written keep their old values.
- R5: In `ST_LOAD`, a write whose page (address bits above bit 6) differs from the page of the first write is ignored.
- R6: Each accepted same-page write in `ST_LOAD` restarts the byte-load timer. The load therefore ends only after `LOAD_TMO` cycles with no accepted write.
- R7: In `ST_PROG`, bit 6 of `ad_o` inverts on each new read strobe, so two successive reads differ in bit 6. After the write cycle completes, reads return the true array contents.
- R8: After reset the machine is in `ST_IDLE`, `ad_oe`=0, and every array byte reads 0x00.
- R9: Writes that arrive during `ST_PROG` are ignored.
- R10: Address bits 6:0 pick the byte inside the buffered page, so distinct offsets of one page land in distinct array bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe: transparent when high, hold on fall |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| rd_n | input | 1 | Active-low data read strobe |
| psen_n | input | 1 | Active-low program-fetch read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a_hi | input | ADDR_W-8 | Dedicated upper address lines |
| ad_i | input | 8 | Shared address-low/data lines, inbound |
| ad_o | output | 8 | Shared lines, outbound read data |
| ad_oe | output | 1 | Output driver enable for the shared lines (high-impedance when 0) |

## Verification
The bench writes two offsets of a page and reads one back at once, while the load is still open. A design that skipped buffering would return the new byte early instead of 0x00. Writes are spaced just inside the load timeout, so a timer that did not restart would enter the write cycle after the first byte and drop the rest. A second page written mid-load, and a write issued during the write cycle, must both leave the array unchanged; a design without the page compare or the busy guard would store them. Two polls in the write cycle must differ in bit 6. The address hold is tested by changing the shared lines after the strobe falls; a design that kept the latch transparent would read the wrong byte.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wr_state_e;
endpackage

// File: rtl/mpx_addr_latch.sv
module mpx_addr_latch #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-9:0] hi,
    input  logic [7:0]        lo,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= '0;
        else if (ale) held <= {hi, lo};
    end

    // transparent while the strobe is high, frozen afterwards
    assign addr = ale ? {hi, lo} : held;

    // R1: on the strobe's fall the used address equals the last value presented
    p_hold_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (addr == $past({hi, lo})));
endmodule

// File: rtl/mpx_wr_ctrl.sv
module mpx_wr_ctrl
    import mpx_pkg::*;
#(
    parameter int PG_W     = 4,
    parameter int LOAD_TMO = 16,
    parameter int PROG_CYC = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_acc,
    input  logic [PG_W-1:0] page_in,
    output wr_state_e       state,
    output logic [PG_W-1:0] page_q,
    output logic            load_en,
    output logic            commit,
    output logic            busy
);
    localparam int CNT_MAX = (LOAD_TMO > PROG_CYC) ? LOAD_TMO : PROG_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    wr_state_e        nxt;
    logic [CNT_W-1:0] cnt;
    logic             same_page;

    assign same_page = (page_in == page_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            page_q <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || load_en) cnt <= '0;
            else                         cnt <= cnt + 1'b1;
            if (state == ST_IDLE && wr_acc) page_q <= page_in;
        end
    end

    always_comb begin
        nxt     = state;
        load_en = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_acc) begin
                    load_en = 1'b1;
                    nxt     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (wr_acc && same_page)             load_en = 1'b1;
                else if (cnt == CNT_W'(LOAD_TMO - 1)) nxt     = ST_PROG;
            end
            ST_PROG: begin
                if (cnt == CNT_W'(PROG_CYC - 1)) begin
                    commit = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign busy = (state == ST_PROG);

    // R4: without a write the idle state is kept
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_acc) |=> (state == ST_IDLE));
    // R9: the write cycle only ends by returning to idle
    p_prog_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> (state == ST_PROG || state == ST_IDLE));
    // R6: a buffered byte during load restarts the timer
    p_load_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && wr_acc && page_in == page_q) |=> (state == ST_LOAD && cnt == '0));
endmodule

// File: rtl/mpx_page_buf.sv
module mpx_page_buf #(
    parameter int OFF_W = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load_en,
    input  logic                               clear,
    input  logic [OFF_W-1:0]                   off,
    input  logic [7:0]                         din,
    output logic [(1<<OFF_W)-1:0][7:0]         bytes,
    output logic [(1<<OFF_W)-1:0]              valid
);
    localparam int NB = 1 << OFF_W;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes[g] <= '0;
                valid[g] <= 1'b0;
            end else if (clear) begin
                valid[g] <= 1'b0;
            end else if (load_en && off == OFF_W'(g)) begin
                bytes[g] <= din;
                valid[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpx_array.sv
module mpx_array #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-OFF_W-1:0]       page,
    input  logic [(1<<OFF_W)-1:0][7:0]    bytes,
    input  logic [(1<<OFF_W)-1:0]         valid,
    input  logic [ADDR_W-1:0]             raddr,
    output logic [7:0]                    rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NB    = 1 << OFF_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int j = 0; j < NB; j++)
                if (valid[j]) mem[{page, OFF_W'(j)}] <= bytes[j];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mpx_page_mem.sv
module mpx_page_mem
    import mpx_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int LOAD_TMO = 16,
    parameter int PROG_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              rd_n,
    input  logic              psen_n,
    input  logic              wr_n,
    input  logic [ADDR_W-9:0] a_hi,
    input  logic [7:0]        ad_i,
    output logic [7:0]        ad_o,
    output logic              ad_oe
);
    localparam int OFF_W = 7;
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int NB    = 1 << OFF_W;

    logic [ADDR_W-1:0]  addr;
    logic               sel, rd_act, rd_q, wr_q, wr_acc, tog;
    wr_state_e          state;
    logic [PG_W-1:0]    page_q;
    logic               load_en, commit, busy;
    logic [NB-1:0][7:0] bytes;
    logic [NB-1:0]      valid;
    logic [7:0]         rdata;

    assign sel    = !ce_n && ce;
    assign rd_act = sel && wr_n && (!rd_n || !psen_n);
    assign wr_acc = sel && !ale && !wr_n && wr_q;

    mpx_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ale(ale), .hi(a_hi), .lo(ad_i), .addr(addr)
    );

    mpx_wr_ctrl #(.PG_W(PG_W), .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .page_in(addr[ADDR_W-1:OFF_W]),
        .state(state), .page_q(page_q), .load_en(load_en), .commit(commit), .busy(busy)
    );

    mpx_page_buf #(.OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .clear(commit),
        .off(addr[OFF_W-1:0]), .din(ad_i), .bytes(bytes), .valid(valid)
    );

    mpx_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(page_q),
        .bytes(bytes), .valid(valid), .raddr(addr), .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_act;
            if (busy && rd_act && !rd_q) tog <= ~tog;
        end
    end

    always_comb begin
        ad_oe = rd_act;
        ad_o  = 8'h00;
        if (rd_act) ad_o = busy ? {rdata[7], tog, rdata[5:0]} : rdata;
    end

    // R3: a deselected part neither drives nor buffers
    p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce) |-> (!ad_oe && !load_en));
    // R7: each new poll in the write cycle flips the status bit
    p_poll_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_act && !rd_q) |=> (tog != $past(tog)));
    // R9: the buffer is never loaded while the write cycle runs
    p_busy_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_en);
endmodule

// File: tb/mpx_page_mem_tb.sv
module mpx_page_mem_tb;
    localparam int LT = 16;
    localparam int PC = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ale = 1'b0, ce_n = 1'b0, ce = 1'b1, rd_n = 1'b1, psen_n = 1'b1, wr_n = 1'b1;
    logic [2:0] a_hi = '0;
    logic [7:0] ad_i = '0;
    logic [7:0] ad_o;
    logic       ad_oe;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mpx_page_mem u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ce_n(ce_n), .ce(ce), .rd_n(rd_n),
        .psen_n(psen_n), .wr_n(wr_n), .a_hi(a_hi), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_addr(logic [10:0] a);
        @(negedge clk);
        ale = 1'b1; a_hi = a[10:8]; ad_i = a[7:0];
        @(negedge clk);
        ale = 1'b0; ad_i = 8'hA5;
    endtask

    task automatic bus_write(logic [10:0] a, logic [7:0] d);
        put_addr(a);
        ad_i = d; wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1;
        idle(1);
    endtask

    task automatic bus_read(logic [10:0] a, bit use_psen, output logic [7:0] d, output logic oe);
        put_addr(a);
        if (use_psen) psen_n = 1'b0; else rd_n = 1'b0;
        idle(2);
        d = ad_o; oe = ad_oe;
        rd_n = 1'b1; psen_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset;
        logic [7:0] d; logic oe;
        check("R8 oe after reset", {7'd0, ad_oe}, 8'h00);
        bus_read(11'h123, 1'b0, d, oe);
        check("R8 array cleared", d, 8'h00);
    endtask

    task automatic t_page_commit;
        logic [7:0] d; logic oe;
        bus_write({4'd1, 7'd3}, 8'h3C);
        bus_write({4'd1, 7'd9}, 8'h91);
        bus_read({4'd1, 7'd3}, 1'b0, d, oe);
        check("R4 not visible during load", d, 8'h00);
        idle(LT + PC + 10);
        bus_read({4'd1, 7'd3}, 1'b0, d, oe);
        check("R4 committed byte", d, 8'h3C);
        check("R2 rd_n drives", {7'd0, oe}, 8'h01);
        bus_read({4'd1, 7'd9}, 1'b0, d, oe);
        check("R10 second offset", d, 8'h91);
        bus_write({4'd1, 7'd4}, 8'h44);
        idle(LT + PC + 10);
        bus_read({4'd1, 7'd3}, 1'b0, d, oe);
        check("R4 unwritten byte kept", d, 8'h3C);
        bus_read({4'd1, 7'd4}, 1'b0, d, oe);
        check("R10 new offset", d, 8'h44);
    endtask

    task automatic t_timer_restart;
        logic [7:0] d; logic oe;
        for (int k = 0; k < 4; k++) begin
            bus_write({4'd2, 7'(k)}, 8'(8'h20 + k));
            idle(8);
        end
        idle(LT + PC + 10);
        for (int k = 0; k < 4; k++) begin
            bus_read({4'd2, 7'(k)}, 1'b0, d, oe);
            check("R6 spaced writes kept", d, 8'(8'h20 + k));
        end
    endtask

    task automatic t_poll;
        logic [7:0] d1, d2, d3; logic oe;
        bus_write({4'd5, 7'd0}, 8'h12);
        idle(LT + 2);
        bus_read({4'd5, 7'd0}, 1'b0, d1, oe);
        bus_read({4'd5, 7'd0}, 1'b1, d2, oe);
        check("R7 bit6 toggles", {7'd0, d1[6] ^ d2[6]}, 8'h01);
        idle(PC + 5);
        bus_read({4'd5, 7'd0}, 1'b0, d3, oe);
        check("R7 true data after cycle", d3, 8'h12);
    endtask

    task automatic t_busy_write;
        logic [7:0] d; logic oe;
        bus_write({4'd6, 7'd1}, 8'h61);
        idle(LT + 2);
        bus_write({4'd6, 7'd2}, 8'h62);
        idle(PC + LT + 10);
        bus_read({4'd6, 7'd2}, 1'b0, d, oe);
        check("R9 write during cycle dropped", d, 8'h00);
        bus_read({4'd6, 7'd1}, 1'b0, d, oe);
        check("R9 earlier byte stored", d, 8'h61);
    endtask

    task automatic t_other_page;
        logic [7:0] d; logic oe;
        bus_write({4'd7, 7'd0}, 8'h70);
        bus_write({4'd8, 7'd0}, 8'h80);
        idle(LT + PC + 10);
        bus_read({4'd7, 7'd0}, 1'b0, d, oe);
        check("R5 first page stored", d, 8'h70);
        bus_read({4'd8, 7'd0}, 1'b0, d, oe);
        check("R5 foreign page ignored", d, 8'h00);
    endtask

    task automatic t_standby;
        logic [7:0] d; logic oe;
        ce_n = 1'b1;
        bus_read({4'd1, 7'd3}, 1'b0, d, oe);
        check("R3 no drive with ce_n high", {7'd0, oe}, 8'h00);
        bus_write({4'd9, 7'd1}, 8'h91);
        ce_n = 1'b0; ce = 1'b0;
        bus_read({4'd1, 7'd3}, 1'b1, d, oe);
        check("R3 no drive with ce low", {7'd0, oe}, 8'h00);
        bus_write({4'd9, 7'd0}, 8'h99);
        ce = 1'b1;
        idle(LT + PC + 10);
        bus_read({4'd9, 7'd0}, 1'b0, d, oe);
        check("R3 write with ce low dropped", d, 8'h00);
        bus_read({4'd9, 7'd1}, 1'b0, d, oe);
        check("R3 write with ce_n high dropped", d, 8'h00);
    endtask

    task automatic t_psen_and_idle;
        logic [7:0] d; logic oe;
        bus_read({4'd1, 7'd9}, 1'b1, d, oe);
        check("R2 psen_n read data", d, 8'h91);
        check("R2 psen_n drives", {7'd0, oe}, 8'h01);
        idle(1);
        check("R2 released without strobe", {7'd0, ad_oe}, 8'h00);
    endtask

    task automatic t_latch;
        @(negedge clk);
        ale = 1'b1; a_hi = 3'd0; ad_i = {1'b1, 7'd3};
        rd_n = 1'b0;
        idle(1);
        check("R1 transparent first", ad_o, 8'h3C);
        ad_i = {1'b1, 7'd9};
        idle(1);
        check("R1 transparent follows", ad_o, 8'h91);
        ale = 1'b0;
        idle(1);
        ad_i = {1'b1, 7'd4}; a_hi = 3'd5;
        idle(1);
        check("R1 held after fall", ad_o, 8'h91);
        rd_n = 1'b1;
        idle(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_page_commit();
        t_timer_restart();
        t_poll();
        t_busy_write();
        t_other_page();
        t_standby();
        t_psen_and_idle();
        t_latch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule